// File: doc/BRIEF.md
# I2C Controller Bus Timing Generator

This block turns one-cycle commands from a byte sequencer into the controller-side waveforms of an I2C bus. It owns the SCL waveform and places every SDA edge: the START and repeated START conditions, each data bit, and the STOP condition. Four programmable counts set the SCL low time, the SCL high time, the setup/hold time around START and STOP, and the delay from the start of the SCL low phase to the SDA change. A power-of-two prescaler slows all four counts together.

Both bus lines are driven as open-drain pull-down enables. The raw SCL and SDA line levels come back through two glitch filters of their own programmable width. The filtered SDA level at the end of each SCL high phase is returned as the received bit, and a one-cycle done pulse marks the end of every command. While the block is not enabled it drives nothing and returns to idle.

Top module: `i2c_bus_timer`

## Requirements
- R1: After reset, and whenever `enable` is 0, both `scl_oe` and `sda_oe` are 0. Clearing `enable` during a transfer releases both lines in the next cycle. A `start_i` strobe while `enable` is 0 drives nothing.
- R2: With prescale P, every timed phase of count N lasts exactly (N+1)*2^P clock cycles, counted from the cycle after the strobe is accepted. P=0 divides by one.
- R3: From idle, `start_i` sets `sda_oe`=1 with `scl_oe`=0 for (t_sethold+1)*2^P cycles. After that both enables are 1 and `done_o` pulses.
- R4: From the held state, `bit_i` starts an SCL low phase of (t_low+1)*2^P cycles. `sda_oe` keeps its old value for the first (t_dvalid+1)*2^P of these cycles and then becomes the inverse of `bit_val_i`. An SCL high phase of (t_high+1)*2^P cycles follows with `sda_oe` unchanged. The block then returns to SCL low and pulses `done_o`.
- R5: `rx_bit` takes the filtered SDA level at the end of the SCL high phase and is valid in the cycle `done_o` pulses. A released line reads 1 and a pulled line reads 0.
- R6: From the held state, `stop_i` gives an SCL low phase of (t_low+1)*2^P cycles with SDA pulled once the data-valid time has passed. Then SCL is released with SDA still pulled for (t_sethold+1)*2^P cycles. Then both lines are released and `done_o` pulses.
- R7: `start_i` in the held state makes a repeated START. SCL stays low for (t_low+1)*2^P cycles, with SDA released after the data-valid time. Both lines are then released for (t_sethold+1)*2^P cycles, followed by the R3 hold phase.
- R8: In idle, only `start_i` is accepted. While a timed phase runs, all strobes are ignored. In the held state, `start_i` takes priority over `stop_i`, and `stop_i` takes priority over `bit_i`.
- R9: Each filter output starts at 1 after reset. It changes only after its raw input has shown the opposite level for width+1 consecutive clock edges, so a pulse of width cycles or fewer is dropped. A width of 1 is supported.
- R10: With P=0, t_low=0x3E, t_high=0x35, t_sethold=0x1D and t_dvalid=0x0F, one SCL period is 117 clock cycles. At a 48 MHz clock this is about 410 kbit/s.
- R11: `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; 0 forces idle and releases the bus |
| prescale | input | PRE_W | Clock divider exponent for the timing counters |
| t_low | input | CNT_W | SCL low count |
| t_high | input | CNT_W | SCL high count |
| t_sethold | input | CNT_W | START/STOP setup and hold count |
| t_dvalid | input | CNT_W | SDA change delay into the SCL low phase |
| flt_scl_w | input | FILT_W | SCL glitch filter width |
| flt_sda_w | input | FILT_W | SDA glitch filter width |
| start_i | input | 1 | Strobe: START or repeated START |
| stop_i | input | 1 | Strobe: STOP |
| bit_i | input | 1 | Strobe: transfer one bit |
| bit_val_i | input | 1 | Bit to send with `bit_i` (1 releases SDA) |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| done_o | output | 1 | One-cycle pulse when a command completes |
| rx_bit | output | 1 | Filtered SDA sampled at the end of SCL high |
| scl_filt | output | 1 | Filtered SCL level |
| sda_filt | output | 1 | Filtered SDA level |

## Verification
Every strobe is accepted at the first rising edge, and the new enable pattern appears right after that edge. The bench therefore samples on falling edges. It counts how many falling edges each (scl_oe, sda_oe) pattern lasts and compares that count with (N+1)*2^P. The count for the SDA change inside a low phase is taken from the split point of the two patterns, which falls at (t_dvalid+1)*2^P. `done_o` and `rx_bit` are checked on the first falling edge of the held or idle pattern and again one edge later. Filter results are checked on the falling edge after exactly width+1 rising edges of the opposite level.

// File: rtl/i2c_bus_timer.sv
module i2c_bus_timer #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 3,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [CNT_W-1:0]  t_low,
  input  logic [CNT_W-1:0]  t_high,
  input  logic [CNT_W-1:0]  t_sethold,
  input  logic [CNT_W-1:0]  t_dvalid,
  input  logic [FILT_W-1:0] flt_scl_w,
  input  logic [FILT_W-1:0] flt_sda_w,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              bit_i,
  input  logic              bit_val_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              done_o,
  output logic              rx_bit,
  output logic              scl_filt,
  output logic              sda_filt
);

  localparam int PC_W = (2 ** PRE_W) - 1;
  localparam logic [PC_W-1:0] PC_ONE = 1;

  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_STH, S_RSL, S_RSS, S_BLO, S_BHI, S_PLO, S_PSU
  } st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt, lim;
  logic [PC_W-1:0]  pre, pmask;
  logic             sda_drv, bitv, tick, ph_end, dv_hit;

  // glitch filters: index 0 = SDA, 1 = SCL
  logic [1:0]       raw, flt_q;
  logic [FILT_W-1:0] fw   [2];
  logic [FILT_W-1:0] fcnt [2];

  assign raw   = {scl_i, sda_i};
  assign fw[0] = flt_sda_w;
  assign fw[1] = flt_scl_w;

  for (genvar g = 0; g < 2; g++) begin : g_flt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flt_q[g] <= 1'b1;
        fcnt[g]  <= '0;
      end else if (raw[g] == flt_q[g]) begin
        fcnt[g]  <= '0;
      end else if (fcnt[g] == fw[g]) begin
        flt_q[g] <= raw[g];
        fcnt[g]  <= '0;
      end else begin
        fcnt[g]  <= fcnt[g] + 1'b1;
      end
    end

    AST_FILT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(flt_q[g]) |-> $past(raw[g]) == flt_q[g]); // R9
  end

  assign sda_filt = flt_q[0];
  assign scl_filt = flt_q[1];

  assign pmask  = (PC_ONE << prescale) - PC_ONE;
  assign tick   = &(pre | ~pmask);
  assign ph_end = tick && (cnt == lim);
  assign dv_hit = tick && (cnt == t_dvalid);

  always_comb begin
    case (st)
      S_STH, S_RSS, S_PSU: lim = t_sethold;
      S_RSL, S_BLO, S_PLO: lim = t_low;
      S_BHI:               lim = t_high;
      default:             lim = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      pre     <= '0;
      sda_drv <= 1'b0;
      bitv    <= 1'b0;
      done_o  <= 1'b0;
      rx_bit  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      pre    <= pre + 1'b1;
      if (!enable) begin
        st      <= S_IDLE;
        sda_drv <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (start_i) begin
            st <= S_STH; cnt <= '0; pre <= '0;
          end
          S_HOLD: if (start_i || stop_i || bit_i) begin
            cnt <= '0; pre <= '0;
            if (start_i)     st <= S_RSL;
            else if (stop_i) st <= S_PLO;
            else begin       st <= S_BLO; bitv <= bit_val_i; end
          end
          default: begin
            if (tick) cnt <= ph_end ? '0 : cnt + 1'b1;
            if (dv_hit || ph_end) begin
              if (st == S_RSL) sda_drv <= 1'b0;
              if (st == S_BLO) sda_drv <= ~bitv;
              if (st == S_PLO) sda_drv <= 1'b1;
            end
            if (ph_end) begin
              case (st)
                S_STH: begin st <= S_HOLD; sda_drv <= 1'b1; done_o <= 1'b1; end
                S_RSL: st <= S_RSS;
                S_RSS: st <= S_STH;
                S_BLO: st <= S_BHI;
                S_BHI: begin st <= S_HOLD; rx_bit <= sda_filt; done_o <= 1'b1; end
                S_PLO: st <= S_PSU;
                S_PSU: begin st <= S_IDLE; sda_drv <= 1'b0; done_o <= 1'b1; end
                default: st <= S_IDLE;
              endcase
            end
          end
        endcase
      end
    end
  end

  assign scl_oe = (st == S_HOLD) || (st == S_RSL) || (st == S_BLO) || (st == S_PLO);
  assign sda_oe = (st == S_STH) || (st == S_PSU) ||
                  (sda_drv && ((st == S_HOLD) || (st == S_BLO) || (st == S_BHI) ||
                               (st == S_PLO)  || (st == S_RSL)));

  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_oe && !sda_oe); // R1
  AST_SDA_FALL_SCL_HIGH_ONLY_START: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_oe && $rose(sda_oe) |-> st == S_STH); // R3
  AST_DATA_STABLE_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_BHI && $past(st) == S_BHI |-> $stable(sda_oe)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_HOLD_ONLY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_HOLD && $past(st) != S_HOLD |-> done_o); // R3

endmodule

// File: tb/i2c_bus_timer_tb_top.sv
module i2c_bus_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [2:0] prescale = '0;
  logic [7:0] t_low = 8'd3, t_high = 8'd2, t_sethold = 8'd4, t_dvalid = 8'd1;
  logic [3:0] flt_scl_w = 4'd1, flt_sda_w = 4'd1;
  logic       start_i = 0, stop_i = 0, bit_i = 0, bit_val_i = 0;
  logic       tgt_low = 0, scl_low = 0;
  logic       scl_oe, sda_oe, done_o, rx_bit, scl_filt, sda_filt;
  wire        scl_i = ~(scl_oe | scl_low);
  wire        sda_i = ~(sda_oe | tgt_low);

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  i2c_bus_timer dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
    .t_low(t_low), .t_high(t_high), .t_sethold(t_sethold), .t_dvalid(t_dvalid),
    .flt_scl_w(flt_scl_w), .flt_sda_w(flt_sda_w),
    .start_i(start_i), .stop_i(stop_i), .bit_i(bit_i), .bit_val_i(bit_val_i),
    .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done_o(done_o), .rx_bit(rx_bit), .scl_filt(scl_filt), .sda_filt(sda_filt)
  );

  // {prescale, t_low, t_high, t_sethold, t_dvalid}
  localparam logic [34:0] VEC [3] = '{
    {3'd0, 8'h3E, 8'h35, 8'h1D, 8'h0F},
    {3'd2, 8'd5,  8'd4,  8'd3,  8'd1},
    {3'd1, 8'd3,  8'd2,  8'd0,  8'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // op: 0 start, 1 stop, 2 bit, 3 start+stop together
  task automatic do_op(input int op, input logic v);
    start_i   = (op == 0) || (op == 3);
    stop_i    = (op == 1) || (op == 3);
    bit_i     = (op == 2);
    bit_val_i = v;
    @(posedge clk);
    @(negedge clk);
    start_i = 0; stop_i = 0; bit_i = 0;
  endtask

  task automatic run_len(input logic es, input logic ed, output int n);
    n = 0;
    while (scl_oe === es && sda_oe === ed && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic glitch_test(input bit on_scl, input int w);
    for (int len = 1; len <= w + 1; len++) begin
      @(negedge clk);
      if (on_scl) scl_low = 1; else tgt_low = 1;
      repeat (len) @(negedge clk);
      scl_low = 0; tgt_low = 0;
      check($sformatf("R9 %s len=%0d w=%0d", on_scl ? "scl" : "sda", len, w),
            on_scl ? scl_filt : sda_filt, (len > w) ? 0 : 1);
      repeat (w + 4) @(negedge clk);
    end
  endtask

  task automatic run_all();
    int n, a, b, p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset scl_oe", scl_oe, 0);
    check("R1 reset sda_oe", sda_oe, 0);
    check("R11 reset done", done_o, 0);
    check("R9 reset sda_filt", sda_filt, 1);
    check("R9 reset scl_filt", scl_filt, 1);

    // R1: start while disabled drives nothing
    do_op(0, 0);
    for (int i = 0; i < 5; i++) begin
      check("R1 disabled drive", {scl_oe, sda_oe}, 0);
      @(negedge clk);
    end

    // R8: bit and stop ignored in idle
    enable = 1;
    @(negedge clk);
    do_op(2, 1);
    do_op(1, 0);
    for (int i = 0; i < 4; i++) begin
      check("R8 idle ignores bit/stop", {scl_oe, sda_oe, done_o}, 0);
      @(negedge clk);
    end

    // Table of timing vectors: start, bit 1, bit 0, stop
    for (int k = 0; k < 3; k++) begin
      {prescale, t_low, t_high, t_sethold, t_dvalid} = VEC[k];
      p = int'(prescale);
      @(negedge clk);
      do_op(0, 0);
      run_len(0, 1, n);
      check("R2 R3 start hold", n, (int'(t_sethold) + 1) << p);
      check("R3 start done", {scl_oe, sda_oe, done_o}, 3'b111);
      @(negedge clk);
      check("R11 done one cycle", done_o, 0);

      do_op(2, 1);
      run_len(1, 1, a);
      check("R4 data valid delay", a, (int'(t_dvalid) + 1) << p);
      run_len(1, 0, b);
      check("R2 R4 low phase", a + b, (int'(t_low) + 1) << p);
      run_len(0, 0, n);
      check("R2 R4 high phase", n, (int'(t_high) + 1) << p);
      check("R5 bit1 done", {scl_oe, done_o, rx_bit}, 3'b111);
      if (k == 0) check("R10 fast mode period", a + b + n, 117);

      do_op(2, 0);
      run_len(1, 0, a);
      run_len(1, 1, b);
      check("R4 bit0 low phase", a + b, (int'(t_low) + 1) << p);
      run_len(0, 1, n);
      check("R4 bit0 high phase", n, (int'(t_high) + 1) << p);
      check("R5 bit0 rx", {done_o, rx_bit}, 2'b10);

      do_op(1, 0);
      run_len(1, 1, a);
      check("R6 stop low phase", a, (int'(t_low) + 1) << p);
      run_len(0, 1, n);
      check("R6 stop setup", n, (int'(t_sethold) + 1) << p);
      check("R6 stop idle", {scl_oe, sda_oe, done_o}, 3'b001);
      @(negedge clk);
    end

    // R8: strobe during a running phase is ignored
    prescale = 0; t_low = 3; t_high = 2; t_sethold = 4; t_dvalid = 1;
    @(negedge clk);
    do_op(0, 0);
    do_op(1, 0);
    run_len(0, 1, n);
    check("R8 stop ignored during start", n, 4);
    repeat (10) @(negedge clk);
    check("R8 held after ignored stop", {scl_oe, sda_oe}, 2'b11);

    // R7 + R8 priority: start and stop together give a repeated START
    do_op(3, 0);
    run_len(1, 1, a);
    check("R7 rs data valid", a, 2);
    run_len(1, 0, b);
    check("R8 R7 start wins over stop", b, 2);
    run_len(0, 0, n);
    check("R7 rs setup", n, 5);
    run_len(0, 1, n);
    check("R7 rs hold", n, 5);
    check("R7 rs done", {scl_oe, sda_oe, done_o}, 3'b111);

    // R1: drop enable while holding the bus
    enable = 0;
    @(negedge clk);
    check("R1 enable drop releases", {scl_oe, sda_oe}, 0);
    enable = 1;
    repeat (2) @(negedge clk);

    // R9 filters
    flt_sda_w = 3; glitch_test(0, 3);
    flt_sda_w = 1; glitch_test(0, 1);
    flt_scl_w = 2; glitch_test(1, 2);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule